// File: doc/BRIEF.md
# Serial-bus byte memory command front end

This block is the slave side of a four-wire serial bus (chip select, serial clock, serial data in, serial data out) in front of a small byte-wide memory. Here the memory is an on-chip register array, and a fixed-length write cycle stands in for nonvolatile programming. The host pulls chip select low and shifts in an 8-bit opcode, most significant bit first. The block decodes it and then either takes a 16-bit address followed by data bytes, exchanges a byte with the status register, or acts on a one-byte command. All pins are sampled into the system clock domain, so the serial clock must run several times slower than the system clock. The serial clock may stop at either level, and the transfer picks up where it stopped.

Array writes go into a page buffer first. The write cycle begins only when chip select rises after a whole number of data bytes. Every array write or status write needs a write-enable latch that was armed earlier. During the write cycle only the status-read and single-byte commands are served. A neighbouring protection unit receives the page base address of the pending write and the stored configuration bits. It returns a permission bit that can veto an array write.

Top module: `spi_nvm_frontend`

## Requirements
- R1: Inputs are sampled on rising SCK edges, and the first rising edge after CS_N falls carries bit 7 of the opcode. The opcodes are 0x06 (arm write enable), 0x04 (disarm, and clear the flag), 0x00 (set flag), 0x05 (read status), 0x01 (write status), 0x03 (read array) and 0x02 (write array). The status byte is {cfg[5:0], wel, wip}: wip at bit 0, wel at bit 1.
- R2: Opcode 0x00 sets the flag (status bit 6). Opcode 0x04 clears both the flag and wel.
- R3: An array write or status write issued while wel is 0 changes neither the array nor the status.
- R4: An array write takes a 16-bit address (MSB first) and then data bytes. The data address wraps inside a 32-byte page. The bytes are stored once chip select rises after a whole number of bytes.
- R5: A read takes a 16-bit address and streams bytes from consecutive addresses for as long as CS_N stays low. Page boundaries are crossed, and the address wraps from 0xFFFF to 0x0000.
- R6: While a write cycle runs, status bit 0 reads 1 and status reads are answered. When the cycle ends, wel is 0.
- R7: While a write cycle runs, read, array-write and status-write commands are ignored, and a read returns 0x00 bytes.
- R8: If CS_N rises before a byte is complete, the command is aborted. No write starts and no latch changes.
- R9: A status write replaces status bits 7:2 at the end of its write cycle, and prot_cfg shows those bits.
- R10: prot_addr shows the page base of the array write in progress. If prot_ok is low when CS_N rises, the buffered bytes are discarded and no write cycle starts.
- R11: Pausing SCK at any point for any length of time does not change the result of a transfer.
- R12: After an unknown opcode, the remaining bits are ignored until CS_N rises.
- R13: SO changes only after a falling SCK edge and stays 0 outside data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| prot_addr | output | 16 | Page base address of the pending array write |
| prot_ok | input | 1 | Permission from the protection unit for the array write |
| prot_cfg | output | 6 | Stored status configuration bits 7:2 |

## Verification
The hardest situation to reach is a command arriving while a write cycle is running, because the cycle starts only on the rising edge of chip select and lasts a fixed number of system clocks. The bench starts a page write and, inside that window, immediately issues a status read, a read and a second write. It then polls the status until bit 0 clears and confirms that only the first write landed. Aborted transfers are produced by raising chip select partway through a byte. Pauses are produced by holding SCK high for hundreds of clocks in the middle of every bit.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

    typedef enum logic [7:0] {
        OP_SETFLAG = 8'h00,
        OP_WRSR    = 8'h01,
        OP_WRITE   = 8'h02,
        OP_READ    = 8'h03,
        OP_WRDI    = 8'h04,
        OP_RDSR    = 8'h05,
        OP_WREN    = 8'h06
    } opcode_e;

    typedef enum logic [1:0] {
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [2:0] {
        XF_NONE,
        XF_READ,
        XF_WRITE,
        XF_WRSR,
        XF_RDSR
    } xfer_e;

    typedef struct packed {
        logic [5:0] cfg;
        logic       wel;
        logic       wip;
    } status_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic idle;
        logic end_xfer;
        logic din;
    } pin_ev_t;

    localparam int FLAG_BIT = 4;

    function automatic logic [7:0] status_byte(status_t s);
        return {s.cfg, s.wel, s.wip};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_nvm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    output pin_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] cs_p, sck_p, si_p;
    logic              cs_last, sck_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p     <= '1;
            sck_p    <= '0;
            si_p     <= '0;
            cs_last  <= 1'b1;
            sck_last <= 1'b0;
        end else begin
            cs_p     <= {cs_p[STAGES-2:0], cs_n};
            sck_p    <= {sck_p[STAGES-2:0], sck};
            si_p     <= {si_p[STAGES-2:0], si};
            cs_last  <= cs_p[TOP];
            sck_last <= sck_p[TOP];
        end
    end

    always_comb begin
        ev.idle     = cs_p[TOP];
        ev.end_xfer = cs_p[TOP] & ~cs_last;
        ev.rise     = sck_p[TOP] & ~sck_last & ~cs_p[TOP];
        ev.fall     = ~sck_p[TOP] & sck_last & ~cs_p[TOP];
        ev.din      = si_p[TOP];
    end

endmodule

// File: rtl/spi_byte_array.sv
module spi_byte_array #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] widx, ridx;

    assign widx  = IDX_W'(waddr % ADDR_W'(DEPTH));
    assign ridx  = IDX_W'(raddr % ADDR_W'(DEPTH));
    assign rdata = mem[ridx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

endmodule

// File: rtl/spi_wr_engine.sv
module spi_wr_engine #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 32,
    parameter int WC_CYCLES  = 2000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     buf_clr,
    input  logic                     buf_we,
    input  logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     arr_start,
    input  logic                     sr_start,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
    input  logic [5:0]               sr_val_in,
    output logic                     wip,
    output logic                     done,
    output logic                     done_sr,
    output logic [5:0]               sr_val_out,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [7:0]               mem_data
);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int CW   = $clog2(WC_CYCLES + 1);

    logic [7:0]           pbuf [PAGE_BYTES];
    logic                 pval [PAGE_BYTES];
    logic                 busy, is_sr;
    logic [CW-1:0]        cnt;
    logic [ADDR_W-PG_W-1:0] base;
    logic [5:0]           srv;
    logic [PG_W-1:0]      slot;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst) begin
                pbuf[g] <= 8'h00;
                pval[g] <= 1'b0;
            end else if (buf_clr) begin
                pval[g] <= 1'b0;
            end else if (buf_we && buf_idx == PG_W'(g)) begin
                pbuf[g] <= buf_data;
                pval[g] <= 1'b1;
            end
        end
    end

    assign slot       = cnt[PG_W-1:0];
    assign wip        = busy;
    assign done       = busy && (cnt == CW'(WC_CYCLES - 1));
    assign done_sr    = done && is_sr;
    assign sr_val_out = srv;
    assign mem_we     = busy && !is_sr && (cnt < CW'(PAGE_BYTES)) && pval[slot];
    assign mem_addr   = {base, slot};
    assign mem_data   = pbuf[slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            is_sr <= 1'b0;
            cnt   <= '0;
            base  <= '0;
            srv   <= '0;
        end else if (!busy) begin
            if (arr_start || sr_start) begin
                busy  <= 1'b1;
                is_sr <= sr_start;
                cnt   <= '0;
                base  <= page_base;
                srv   <= sr_val_in;
            end
        end else begin
            cnt <= cnt + CW'(1);
            if (done) busy <= 1'b0;
        end
    end

    a_r6_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (arr_start || sr_start) |=> wip);
    a_r7_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        (arr_start || sr_start) |-> !wip);
    a_r4_store_inside_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(busy) || $past(arr_start));

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_nvm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  pin_ev_t                  ev,
    output logic                     so,
    input  logic                     wip,
    input  logic                     eng_done,
    input  logic                     eng_done_sr,
    input  logic [5:0]               eng_sr_val,
    input  logic [7:0]               rd_data,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     buf_clr,
    output logic                     buf_we,
    output logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
    output logic [7:0]               buf_data,
    output logic                     arr_start,
    output logic                     sr_start,
    output logic [5:0]               sr_data,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
    output logic [5:0]               cfg_o,
    input  logic                     prot_ok
);
    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int ABYTES = ADDR_W / 8;
    localparam int ABW    = (ABYTES > 1) ? $clog2(ABYTES) : 1;

    phase_e          ph;
    xfer_e           kind;
    logic [6:0]      shreg;
    logic [2:0]      bcnt;
    logic [ADDR_W-1:0] addr;
    logic [ABW-1:0]  acnt;
    logic            got_data, load_pend, so_q, wel_q;
    logic [6:0]      out_sr;
    logic [5:0]      cfg_q, sr_hold;
    logic [7:0]      byte_now, tx;
    logic            byte_done;
    status_t         st;

    assign byte_now  = {shreg, ev.din};
    assign byte_done = ev.rise && (bcnt == 3'd7);
    assign st        = '{cfg: cfg_q, wel: wel_q, wip: wip};
    assign tx        = (kind == XF_RDSR) ? status_byte(st) : rd_data;

    assign so        = so_q;
    assign rd_addr   = addr;
    assign buf_idx   = addr[PG_W-1:0];
    assign buf_data  = byte_now;
    assign page_base = addr[ADDR_W-1:PG_W];
    assign cfg_o     = cfg_q;
    assign sr_data   = sr_hold;

    assign buf_we    = byte_done && ph == PH_DATA && kind == XF_WRITE;
    assign buf_clr   = byte_done && ph == PH_OPC && byte_now == OP_WRITE && wel_q && !wip;
    assign arr_start = ev.end_xfer && ph == PH_DATA && kind == XF_WRITE &&
                       bcnt == 3'd0 && got_data && prot_ok;
    assign sr_start  = ev.end_xfer && ph == PH_DATA && kind == XF_WRSR &&
                       bcnt == 3'd0 && got_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_OPC;
            kind      <= XF_NONE;
            shreg     <= '0;
            bcnt      <= '0;
            addr      <= '0;
            acnt      <= '0;
            got_data  <= 1'b0;
            load_pend <= 1'b0;
            so_q      <= 1'b0;
            out_sr    <= '0;
            wel_q     <= 1'b0;
            cfg_q     <= '0;
            sr_hold   <= '0;
        end else begin
            if (eng_done) begin
                wel_q <= 1'b0;
                if (eng_done_sr) cfg_q <= eng_sr_val;
            end
            if (ev.idle) begin
                ph        <= PH_OPC;
                kind      <= XF_NONE;
                bcnt      <= '0;
                acnt      <= '0;
                got_data  <= 1'b0;
                load_pend <= 1'b0;
                so_q      <= 1'b0;
                out_sr    <= '0;
            end else begin
                if (ev.rise) begin
                    shreg <= byte_now[6:0];
                    bcnt  <= bcnt + 3'd1;
                    if (bcnt == 3'd7) begin
                        unique case (ph)
                            PH_OPC: begin
                                ph <= PH_SKIP;
                                case (opcode_e'(byte_now))
                                    OP_WREN:    wel_q <= 1'b1;
                                    OP_WRDI: begin
                                        wel_q           <= 1'b0;
                                        cfg_q[FLAG_BIT] <= 1'b0;
                                    end
                                    OP_SETFLAG: cfg_q[FLAG_BIT] <= 1'b1;
                                    OP_RDSR: begin
                                        kind      <= XF_RDSR;
                                        ph        <= PH_DATA;
                                        load_pend <= 1'b1;
                                    end
                                    OP_READ: if (!wip) begin
                                        kind <= XF_READ;
                                        ph   <= PH_ADDR;
                                    end
                                    OP_WRITE: if (!wip && wel_q) begin
                                        kind <= XF_WRITE;
                                        ph   <= PH_ADDR;
                                    end
                                    OP_WRSR: if (!wip && wel_q) begin
                                        kind <= XF_WRSR;
                                        ph   <= PH_DATA;
                                    end
                                    default: ph <= PH_SKIP;
                                endcase
                            end
                            PH_ADDR: begin
                                addr <= {addr[ADDR_W-9:0], byte_now};
                                acnt <= acnt + ABW'(1);
                                if (acnt == ABW'(ABYTES - 1)) begin
                                    ph <= PH_DATA;
                                    if (kind == XF_READ) load_pend <= 1'b1;
                                end
                            end
                            PH_DATA: begin
                                got_data <= 1'b1;
                                if (kind == XF_WRITE)
                                    addr[PG_W-1:0] <= addr[PG_W-1:0] + PG_W'(1);
                                if (kind == XF_READ || kind == XF_RDSR)
                                    load_pend <= 1'b1;
                                if (kind == XF_WRSR && !got_data)
                                    sr_hold <= byte_now[7:2];
                            end
                            PH_SKIP: ;
                        endcase
                    end
                end
                if (ev.fall) begin
                    if (load_pend) begin
                        so_q      <= tx[7];
                        out_sr    <= tx[6:0];
                        load_pend <= 1'b0;
                        if (kind == XF_READ) addr <= addr + ADDR_W'(1);
                    end else begin
                        so_q   <= out_sr[6];
                        out_sr <= {out_sr[5:0], 1'b0};
                    end
                end
            end
        end
    end

    a_r13_so_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (so_q != $past(so_q)) |-> ($past(ev.fall) || $past(ev.idle)));
    a_r3_write_needs_wel: assert property (@(posedge clk) disable iff (rst)
        (arr_start || sr_start) |-> wel_q);
    a_r6_wel_cleared_after_cycle: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !ev.rise) |=> !wel_q);
    a_r13_so_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        $past(ev.idle) |-> !so_q);

endmodule

// File: rtl/spi_nvm_frontend.sv
module spi_nvm_frontend
    import spi_nvm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 32,
    parameter int MEM_DEPTH  = 1024,
    parameter int WC_CYCLES  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic [ADDR_W-1:0] prot_addr,
    input  logic              prot_ok,
    output logic [5:0]        prot_cfg
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    pin_ev_t           ev;
    logic              wip, done, done_sr, buf_clr, buf_we, arr_start, sr_start, mem_we;
    logic [PG_W-1:0]   buf_idx;
    logic [7:0]        buf_data, rd_data, mem_data;
    logic [5:0]        sr_data, sr_val;
    logic [ADDR_W-1:0] rd_addr, mem_addr;
    logic [ADDR_W-PG_W-1:0] page_base;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .ev(ev)
    );

    spi_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
        .clk(clk), .rst(rst), .ev(ev), .so(so), .wip(wip),
        .eng_done(done), .eng_done_sr(done_sr), .eng_sr_val(sr_val),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
        .arr_start(arr_start), .sr_start(sr_start), .sr_data(sr_data),
        .page_base(page_base), .cfg_o(prot_cfg), .prot_ok(prot_ok)
    );

    spi_wr_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WC_CYCLES(WC_CYCLES)) u_eng (
        .clk(clk), .rst(rst), .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_data(buf_data), .arr_start(arr_start), .sr_start(sr_start),
        .page_base(page_base), .sr_val_in(sr_data), .wip(wip), .done(done),
        .done_sr(done_sr), .sr_val_out(sr_val), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    spi_byte_array #(.DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign prot_addr = {page_base, PG_W'(0)};

endmodule

// File: tb/test_spi_nvm_frontend.sv
module test_spi_nvm_frontend;
    localparam int WC = 1500, HALF = 8, DEPTH = 1024;

    logic clk = 0, rst = 1, cs_n = 1, sck = 0, si = 0, prot_ok = 1;
    logic so;
    logic [15:0] prot_addr;
    logic [5:0]  prot_cfg;

    always #4 clk = ~clk;

    spi_nvm_frontend #(.MEM_DEPTH(DEPTH), .WC_CYCLES(WC)) i_spi_nvm_frontend (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
        .prot_addr(prot_addr), .prot_ok(prot_ok), .prot_cfg(prot_cfg)
    );

    int n_chk = 0, n_fail = 0, pause_clks = 0;
    logic [7:0]  mem_m [DEPTH];
    logic        wel_m = 0;
    logic [5:0]  cfg_m = 0;
    logic [15:0] pend_a [$];
    logic [7:0]  pend_d [$];
    bit          pend_any = 0, pend_sr = 0;
    logic [5:0]  pend_cfg;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(logic b, output logic o);
        logic mid;
        si = b;
        tick(HALF);
        o = so;
        sck = 1;
        tick(HALF / 2);
        mid = so;
        check("R13 SO steady while SCK high", mid, o);
        tick(HALF / 2 + pause_clks);
        sck = 0;
    endtask

    task automatic xbyte(logic [7:0] b, output logic [7:0] o);
        for (int i = 7; i >= 0; i--) bit_io(b[i], o[i]);
    endtask

    task automatic send(logic [7:0] b);
        logic [7:0] d;
        xbyte(b, d);
    endtask

    task automatic sel();
        tick(HALF); cs_n = 0; tick(HALF);
    endtask

    task automatic desel();
        tick(HALF); cs_n = 1; tick(3 * HALF);
    endtask

    task automatic simple(logic [7:0] op);
        sel(); send(op); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        sel(); send(8'h05); xbyte(8'h00, s); desel();
    endtask

    task automatic chk_stat(string req, bit busy = 0);
        logic [7:0] s;
        rdsr(s);
        check(req, s, {cfg_m, wel_m, busy});
    endtask

    task automatic do_read(logic [15:0] a, int n, string req, bit busy = 0);
        logic [7:0] d;
        sel(); send(8'h03); send(a[15:8]); send(a[7:0]);
        for (int i = 0; i < n; i++) begin
            logic [15:0] ai;
            ai = a + 16'(i);
            xbyte(8'h00, d);
            check(req, d, busy ? 0 : mem_m[ai % DEPTH]);
        end
        desel();
    endtask

    task automatic do_write(logic [15:0] a, logic [7:0] q [$], int extra, bit chk_prot);
        logic o;
        sel(); send(8'h02); send(a[15:8]); send(a[7:0]);
        foreach (q[i]) send(q[i]);
        for (int i = 0; i < extra; i++) bit_io(1'b1, o);
        if (chk_prot) check("R10 prot_addr is page base", prot_addr, a & 16'hFFE0);
        desel();
        if (wel_m && !pend_any && prot_ok && extra == 0 && q.size() > 0) begin
            pend_any = 1;
            pend_sr  = 0;
            foreach (q[i]) begin
                pend_a.push_back({a[15:5], 5'(a[4:0] + 5'(i))});
                pend_d.push_back(q[i]);
            end
        end
    endtask

    task automatic do_wrsr(logic [7:0] v);
        sel(); send(8'h01); send(v); desel();
        if (wel_m && !pend_any) begin
            pend_any = 1; pend_sr = 1; pend_cfg = v[7:2];
        end
    endtask

    task automatic wait_idle(string req);
        logic [7:0] s;
        for (int i = 0; i < 40; i++) begin
            rdsr(s);
            if (s[0] == 1'b0) break;
        end
        check(req, s[0], 0);
        if (pend_any) begin
            while (pend_a.size() > 0) mem_m[pend_a.pop_front() % DEPTH] = pend_d.pop_front();
            if (pend_sr) cfg_m = pend_cfg;
            wel_m = 0;
            pend_any = 0;
        end
    endtask

    initial begin
        tick(190000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
        tick(10);
        rst = 0;
        tick(10);
        check("R13 SO low after reset", so, 0);
        check("R9 prot_cfg after reset", prot_cfg, 0);
        chk_stat("R1 status after reset");

        // R3: writes without the enable latch
        do_write(16'h0010, '{8'hAA}, 0, 0);
        do_wrsr(8'hFC);
        tick(WC + 100);
        chk_stat("R3 status unchanged without wel");
        do_read(16'h0010, 1, "R3 array unchanged without wel");

        // R12: unknown opcode followed by an enable pattern
        sel(); send(8'h77); send(8'h06); desel();
        chk_stat("R12 unknown opcode ignored");

        // R1: arm enable
        simple(8'h06); wel_m = 1;
        chk_stat("R1 wel set by 0x06");

        // R8: aborted disarm
        begin
            logic o;
            sel();
            for (int i = 0; i < 5; i++) bit_io(1'b0, o);
            desel();
        end
        chk_stat("R8 aborted opcode has no effect");

        // R4/R6/R7/R10: page write with wrap, commands during the cycle
        do_write(16'h001E, '{8'h11, 8'h22, 8'h33, 8'h44}, 0, 1);
        chk_stat("R6 wip and wel during cycle", 1);
        do_read(16'h001E, 2, "R7 read ignored during cycle", 1);
        do_write(16'h0100, '{8'h55}, 0, 0);
        wait_idle("R6 wip clears");
        chk_stat("R6 wel cleared after cycle");
        do_read(16'h001E, 2, "R4 bytes before page end");
        do_read(16'h0000, 2, "R4 bytes wrapped in page");
        do_read(16'h0100, 1, "R7 write during cycle ignored");

        // R5: streaming across a page boundary and address wrap
        do_read(16'h001C, 8, "R5 stream across page");
        do_read(16'hFFFF, 2, "R5 address wraps to zero");

        // R8: partial data byte
        simple(8'h06); wel_m = 1;
        do_write(16'h0040, '{8'h5A}, 3, 0);
        chk_stat("R8 partial byte starts no cycle");
        do_read(16'h0040, 1, "R8 partial byte not stored");

        // R10: protection veto
        prot_ok = 0;
        do_write(16'h0050, '{8'h77}, 0, 1);
        chk_stat("R10 vetoed write starts no cycle");
        prot_ok = 1;
        do_read(16'h0050, 1, "R10 vetoed byte not stored");

        // R11: paused serial clock
        pause_clks = 200;
        do_write(16'h0060, '{8'hC3, 8'h3C}, 0, 0);
        wait_idle("R11 paused write completes");
        do_read(16'h0060, 2, "R11 paused read");
        pause_clks = 0;

        // R2: flag set and clear
        simple(8'h00); cfg_m[4] = 1;
        chk_stat("R2 flag set");
        simple(8'h04); cfg_m[4] = 0; wel_m = 0;
        chk_stat("R2 flag and wel cleared");

        // R9: status write
        simple(8'h06); wel_m = 1;
        do_wrsr(8'hFC);
        wait_idle("R9 status cycle completes");
        chk_stat("R9 status bits written");
        check("R9 prot_cfg follows status", prot_cfg, 6'h3F);
        simple(8'h04); cfg_m[4] = 0; wel_m = 0;
        chk_stat("R2 flag cleared after status write");

        // R7: status write during a cycle is ignored
        simple(8'h06); wel_m = 1;
        do_write(16'h0070, '{8'h99}, 0, 0);
        do_wrsr(8'h00);
        wait_idle("R7 cycle completes");
        chk_stat("R7 status write during cycle ignored");
        do_read(16'h0070, 1, "R4 single byte stored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule